// File: doc/BRIEF.md
# Multi-Sector Transfer Sequencer

This block keeps the running state of a disk transfer that spans several sectors. A start strobe loads a memory address, a byte count, a starting cylinder/head/sector, a unit-select field and a write flag. Each sector-done strobe then moves the transfer forward by one sector. The number of bytes moved is the sector length, clipped to the bytes still owed. The sector length comes from a size code and a short-record length. The remaining count falls by that amount. The transferred count and the memory address rise by the same amount.

The disk position advances in the same cycle. The sector number counts up to the end-of-track value and then returns to 1. A wrap flips the head from 0 to 1. On a wrap from head 1, the head returns to 0 and the cylinder steps by one. The transfer is finished when the remaining count is zero. At that point further sector strobes are ignored. A completion byte is also produced: it holds the unit bits alone, and on a finished write the seek-end bit is added. Moving the data itself is left to the surrounding logic.

Top module: `xseq_top`

## Requirements
- R1: A start strobe loads the address, remaining count, cylinder, head, sector, unit bits and write flag on the next clock edge, and clears the transferred count. Start wins over a sector strobe in the same cycle.
- R2: The sector length is `dtl` when `n_code` is 0, and otherwise `n_code` times 512.
- R3: The bytes moved per sector are the smaller of the sector length and the remaining count, so the remaining count never wraps below zero.
- R4: On an accepted sector strobe, the remaining count decreases by the bytes moved, and the transferred count and memory address each increase by the same amount, on the next clock edge.
- R5: On an accepted sector strobe with the sector number not equal to `eot`, the sector number increments and the head and cylinder are unchanged.
- R6: On an accepted sector strobe with the sector number equal to `eot` and head 0, the sector becomes 1, the head becomes 1 and the cylinder is unchanged.
- R7: On an accepted sector strobe with the sector number equal to `eot` and head 1, the sector becomes 1, the head becomes 0 and the cylinder increments.
- R8: `done` is high exactly when the remaining count is zero. After reset, all counters and the disk address are zero, `st0` is zero and `done` is high.
- R9: A sector strobe while `done` is high changes no counter, address or disk position.
- R10: After a start, `st0` equals the unit bits in bits 2:0. When a write transfer reaches a zero remaining count, `st0` becomes 0x20 ORed with the unit bits. A read completion leaves `st0` at the unit bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load strobe for a new transfer |
| ld_addr | input | 24 | Starting memory address |
| ld_count | input | 16 | Requested byte count |
| ld_cyl | input | 8 | Starting cylinder |
| ld_head | input | 1 | Starting head |
| ld_sec | input | 8 | Starting sector number |
| ld_unit | input | 3 | Head/unit bits reported in the completion byte |
| ld_write | input | 1 | 1 for a write transfer |
| sec_done | input | 1 | One-cycle strobe at the end of each sector |
| n_code | input | 8 | Sector size code (0 selects short-record length) |
| dtl | input | 8 | Short-record length in bytes |
| eot | input | 8 | Last sector number on a track |
| mem_addr | output | 24 | Current memory address |
| bytes_left | output | 16 | Remaining byte count |
| bytes_done | output | 16 | Transferred byte count |
| cur_cyl | output | 8 | Current cylinder |
| cur_head | output | 1 | Current head |
| cur_sec | output | 8 | Current sector number |
| st0 | output | 8 | Completion status byte |
| done | output | 1 | Remaining count is zero |

## Verification
A start strobe or a sector strobe takes effect at the first rising edge after it. At that same edge, the counters, the address, the disk position and `st0` all take their new values. `done` is decoded from the remaining-count register, so it changes at that same edge and has no extra cycle of delay. The bench changes inputs on the falling edge and holds each strobe for exactly one rising edge. It reads every result on the following falling edge, one full register stage after the stimulus. For the ignored-strobe case it reads all outputs both before and after the strobe.

// File: rtl/xseq_pkg.sv
package xseq_pkg;

    localparam int CYL_W = 8;
    localparam int SEC_W = 8;
    localparam int UNIT_W = 3;
    localparam int ST0_W = 8;

    localparam logic [ST0_W-1:0] ST0_SEEK_END = 8'h20;

    typedef struct packed {
        logic [CYL_W-1:0] cyl;
        logic             head;
        logic [SEC_W-1:0] sec;
    } chs_t;

    // Next disk position after one sector; head flips first, cylinder follows.
    function automatic chs_t chs_next(input chs_t cur, input logic [SEC_W-1:0] last_sec);
        chs_t nxt;
        nxt = cur;
        if (cur.sec == last_sec) begin
            nxt.sec = SEC_W'(1);
            if (cur.head) begin
                nxt.head = 1'b0;
                nxt.cyl  = cur.cyl + CYL_W'(1);
            end else begin
                nxt.head = 1'b1;
            end
        end else begin
            nxt.sec = cur.sec + SEC_W'(1);
        end
        return nxt;
    endfunction

endpackage

// File: rtl/xseq_len.sv
module xseq_len #(
    parameter int N_W   = 8,
    parameter int DTL_W = 8,
    parameter int CNT_W = 16
) (
    input  logic [N_W-1:0]   n_code,
    input  logic [DTL_W-1:0] dtl,
    input  logic [CNT_W-1:0] remaining,
    output logic [CNT_W-1:0] moved
);
    localparam int LEN_W = (N_W + 9 > DTL_W) ? N_W + 9 : DTL_W;
    localparam int CMP_W = (LEN_W > CNT_W) ? LEN_W : CNT_W;

    logic [CMP_W-1:0] sec_len;
    logic [CMP_W-1:0] rem_w;

    always_comb begin
        if (n_code == '0)
            sec_len = CMP_W'(dtl);
        else
            sec_len = CMP_W'(n_code) << 9;
        rem_w = CMP_W'(remaining);
        if (sec_len < rem_w)
            moved = CNT_W'(sec_len);
        else
            moved = remaining;
    end
endmodule

// File: rtl/xseq_cnt.sv
module xseq_cnt #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              step,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [CNT_W-1:0]  ld_count,
    input  logic [CNT_W-1:0]  moved,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  left,
    output logic [CNT_W-1:0]  xfer
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            left <= '0;
            xfer <= '0;
        end else if (start) begin
            addr <= ld_addr;
            left <= ld_count;
            xfer <= '0;
        end else if (step) begin
            addr <= addr + ADDR_W'(moved);
            left <= left - moved;
            xfer <= xfer + moved;
        end
    end
endmodule

// File: rtl/xseq_chs.sv
module xseq_chs
    import xseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             step,
    input  chs_t             ld_pos,
    input  logic [SEC_W-1:0] eot,
    output chs_t             pos
);
    always_ff @(posedge clk) begin
        if (rst)
            pos <= '0;
        else if (start)
            pos <= ld_pos;
        else if (step)
            pos <= chs_next(pos, eot);
    end
endmodule

// File: rtl/xseq_top.sv
module xseq_top
    import xseq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int N_W    = 8,
    parameter int DTL_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [CNT_W-1:0]  ld_count,
    input  logic [CYL_W-1:0]  ld_cyl,
    input  logic              ld_head,
    input  logic [SEC_W-1:0]  ld_sec,
    input  logic [UNIT_W-1:0] ld_unit,
    input  logic              ld_write,
    input  logic              sec_done,
    input  logic [N_W-1:0]    n_code,
    input  logic [DTL_W-1:0]  dtl,
    input  logic [SEC_W-1:0]  eot,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CNT_W-1:0]  bytes_left,
    output logic [CNT_W-1:0]  bytes_done,
    output logic [CYL_W-1:0]  cur_cyl,
    output logic              cur_head,
    output logic [SEC_W-1:0]  cur_sec,
    output logic [ST0_W-1:0]  st0,
    output logic              done
);
    logic             step;
    logic [CNT_W-1:0] moved;
    chs_t             ld_pos;
    chs_t             pos;
    logic [UNIT_W-1:0] unit_q;
    logic             write_q;

    assign done   = (bytes_left == '0);
    assign step   = sec_done & ~done & ~start;
    assign ld_pos = '{cyl: ld_cyl, head: ld_head, sec: ld_sec};

    xseq_len #(.N_W(N_W), .DTL_W(DTL_W), .CNT_W(CNT_W)) u_len (
        .n_code    (n_code),
        .dtl       (dtl),
        .remaining (bytes_left),
        .moved     (moved)
    );

    xseq_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .step     (step),
        .ld_addr  (ld_addr),
        .ld_count (ld_count),
        .moved    (moved),
        .addr     (mem_addr),
        .left     (bytes_left),
        .xfer     (bytes_done)
    );

    xseq_chs u_chs (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .step   (step),
        .ld_pos (ld_pos),
        .eot    (eot),
        .pos    (pos)
    );

    assign cur_cyl  = pos.cyl;
    assign cur_head = pos.head;
    assign cur_sec  = pos.sec;

    // Completion byte: unit bits, plus seek-end on a finished write.
    always_ff @(posedge clk) begin
        if (rst) begin
            st0     <= '0;
            unit_q  <= '0;
            write_q <= 1'b0;
        end else if (start) begin
            st0     <= ST0_W'(ld_unit);
            unit_q  <= ld_unit;
            write_q <= ld_write;
        end else if (step && write_q && (moved == bytes_left)) begin
            st0 <= ST0_SEEK_END | ST0_W'(unit_q);
        end
    end
endmodule

// File: rtl/xseq_chk.sv
module xseq_chk
    import xseq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              sec_done,
    input logic [SEC_W-1:0]  eot,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [CNT_W-1:0]  bytes_left,
    input logic [CNT_W-1:0]  bytes_done,
    input logic [CYL_W-1:0]  cur_cyl,
    input logic              cur_head,
    input logic [SEC_W-1:0]  cur_sec,
    input logic              done
);
    // R4: remaining plus transferred is conserved across a sector
    a_r4_conserve: assert property (@(posedge clk) disable iff (rst)
        (sec_done && !done && !start) |=>
        ({1'b0, bytes_left} + {1'b0, bytes_done}) ==
        ($past({1'b0, bytes_left}) + $past({1'b0, bytes_done})));

    // R3: remaining count never grows on a sector
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (sec_done && !start) |=> bytes_left <= $past(bytes_left));

    // R9: strobe while done leaves everything alone
    a_r9_ignore: assert property (@(posedge clk) disable iff (rst)
        (sec_done && done && !start) |=>
        ($stable(bytes_left) && $stable(bytes_done) && $stable(mem_addr) &&
         $stable(cur_sec) && $stable(cur_head) && $stable(cur_cyl)));

    // R5: mid-track sector step
    a_r5_sector_step: assert property (@(posedge clk) disable iff (rst)
        (sec_done && !done && !start && cur_sec != eot) |=>
        (cur_sec == $past(cur_sec) + SEC_W'(1) && $stable(cur_head) && $stable(cur_cyl)));

    // R7: wrap from head 1 steps cylinder
    a_r7_cyl_step: assert property (@(posedge clk) disable iff (rst)
        (sec_done && !done && !start && cur_sec == eot && cur_head) |=>
        (cur_sec == SEC_W'(1) && !cur_head && cur_cyl == $past(cur_cyl) + CYL_W'(1)));

    // R6: wrap from head 0 flips head only
    a_r6_head_flip: assert property (@(posedge clk) disable iff (rst)
        (sec_done && !done && !start && cur_sec == eot && !cur_head) |=>
        (cur_sec == SEC_W'(1) && cur_head && $stable(cur_cyl)));
endmodule

bind xseq_top xseq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .sec_done   (sec_done),
    .eot        (eot),
    .mem_addr   (mem_addr),
    .bytes_left (bytes_left),
    .bytes_done (bytes_done),
    .cur_cyl    (cur_cyl),
    .cur_head   (cur_head),
    .cur_sec    (cur_sec),
    .done       (done)
);

// File: tb/xseq_tb.sv
module xseq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [23:0] ld_addr = '0;
    logic [15:0] ld_count = '0;
    logic [7:0]  ld_cyl = '0;
    logic        ld_head = 1'b0;
    logic [7:0]  ld_sec = '0;
    logic [2:0]  ld_unit = '0;
    logic        ld_write = 1'b0;
    logic        sec_done = 1'b0;
    logic [7:0]  n_code = '0;
    logic [7:0]  dtl = '0;
    logic [7:0]  eot = 8'd9;
    logic [23:0] mem_addr;
    logic [15:0] bytes_left, bytes_done;
    logic [7:0]  cur_cyl, cur_sec, st0;
    logic        cur_head, done;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    xseq_top dut_i (
        .clk(clk), .rst(rst), .start(start), .ld_addr(ld_addr), .ld_count(ld_count),
        .ld_cyl(ld_cyl), .ld_head(ld_head), .ld_sec(ld_sec), .ld_unit(ld_unit),
        .ld_write(ld_write), .sec_done(sec_done), .n_code(n_code), .dtl(dtl), .eot(eot),
        .mem_addr(mem_addr), .bytes_left(bytes_left), .bytes_done(bytes_done),
        .cur_cyl(cur_cyl), .cur_head(cur_head), .cur_sec(cur_sec), .st0(st0), .done(done)
    );

    // Vector table: size code, short length, requested count, expected bytes moved
    localparam int NV = 7;
    localparam int V_N   [NV] = '{2,    0,    0,   1,   4,     200,   0};
    localparam int V_DTL [NV] = '{255,  128,  128, 0,   0,     0,     0};
    localparam int V_CNT [NV] = '{3000, 1000, 100, 512, 65535, 40000, 50};
    localparam int V_MOV [NV] = '{1024, 128,  100, 512, 2048,  40000, 0};

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start(input int a, input int c, input int cy, input int h,
                            input int s, input int u, input int w);
        @(negedge clk);
        ld_addr = 24'(a); ld_count = 16'(c); ld_cyl = 8'(cy); ld_head = h[0];
        ld_sec = 8'(s); ld_unit = 3'(u); ld_write = w[0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse;
        @(negedge clk);
        sec_done = 1'b1;
        @(negedge clk);
        sec_done = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk("R8 reset left", bytes_left, 0);
        chk("R8 reset done", done, 1);
        chk("R8 reset addr", mem_addr, 0);
        chk("R8 reset st0", st0, 0);

        // R1 load
        do_start(24'h123456, 777, 3, 1, 4, 6, 0);
        chk("R1 addr", mem_addr, 24'h123456);
        chk("R1 left", bytes_left, 777);
        chk("R1 xfer", bytes_done, 0);
        chk("R1 cyl", cur_cyl, 3);
        chk("R1 head", cur_head, 1);
        chk("R1 sec", cur_sec, 4);
        chk("R8 done low", done, 0);
        chk("R10 st0 after start", st0, 6);

        // R2 R3 R4 via table
        for (int i = 0; i < NV; i++) begin
            n_code = 8'(V_N[i]);
            dtl = 8'(V_DTL[i]);
            do_start(1000, V_CNT[i], 0, 0, 1, 0, 0);
            pulse();
            chk("R2/R3 R4 left", bytes_left, V_CNT[i] - V_MOV[i]);
            chk("R4 xfer", bytes_done, V_MOV[i]);
            chk("R4 addr", mem_addr, 1000 + V_MOV[i]);
            chk("R8 done", done, (V_CNT[i] == V_MOV[i]) ? 1 : 0);
        end

        // R5 R6 R7 position stepping, eot=3
        n_code = 8'd1; eot = 8'd3;
        do_start(0, 60000, 5, 0, 2, 0, 0);
        pulse();
        chk("R5 sec", cur_sec, 3);
        chk("R5 head", cur_head, 0);
        pulse();
        chk("R6 sec", cur_sec, 1);
        chk("R6 head", cur_head, 1);
        chk("R6 cyl", cur_cyl, 5);
        pulse(); pulse();
        chk("R5 sec h1", cur_sec, 3);
        pulse();
        chk("R7 sec", cur_sec, 1);
        chk("R7 head", cur_head, 0);
        chk("R7 cyl", cur_cyl, 6);
        chk("R4 five sectors", bytes_done, 2560);

        // R10 write completion, R9 ignore after done
        n_code = 8'd0; dtl = 8'd128; eot = 8'd9;
        do_start(500, 200, 0, 0, 1, 5, 1);
        pulse();
        chk("R10 write mid st0", st0, 5);
        pulse();
        chk("R10 write end st0", st0, 8'h25);
        chk("R3 clip end left", bytes_left, 0);
        chk("R4 end addr", mem_addr, 700);
        pulse();
        chk("R9 left", bytes_left, 0);
        chk("R9 xfer", bytes_done, 200);
        chk("R9 addr", mem_addr, 700);
        chk("R9 sec", cur_sec, 3);

        // R10 read completion
        do_start(0, 128, 0, 0, 1, 5, 0);
        pulse();
        chk("R10 read end st0", st0, 5);
        chk("R8 read done", done, 1);

        // R1 start wins over strobe
        @(negedge clk);
        ld_count = 16'd300; ld_addr = 24'd9; ld_sec = 8'd7; start = 1'b1; sec_done = 1'b1;
        @(negedge clk);
        start = 1'b0; sec_done = 1'b0;
        chk("R1 start priority left", bytes_left, 300);
        chk("R1 start priority sec", cur_sec, 7);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule